// File: doc/BRIEF.md
# Accumulator-Carry Pulse Density DAC

This block turns up to four 8-bit duty values into pulse-density bit streams for external RC low-pass filters. Each channel keeps a wrapping 8-bit phase accumulator. On every update tick the channel's duty value is added to that accumulator. The carry out of bit 7 sets the channel's output high for that tick. When there is no carry the output is low. Over 256 ticks the fraction of high ticks is exactly duty/256. The high ticks are spread out across the window rather than gathered into one pulse, which relaxes the filter's corner frequency.

An internal divider sets the tick rate from the system clock. Each tick the output word starts from all zeros and each channel that carried sets its own bit. The whole word is then registered onto the port at once, with channels on the even port bits and every odd bit held low. A host loads duty values at any time through a write strobe, a channel address and a data byte. It can step them every tick to make ramps or sawtooth shapes, and the accumulators are never cleared by a write. A one-cycle tick strobe marks the cycle in which a new port word appears.

Top module: `pdm_dac_bank`

## Requirements
- R1: After reset the port word, the tick strobe, every accumulator and every duty register are zero. With no writes, the port stays all zero across any number of ticks.
- R2: The tick strobe is high for exactly one clock cycle every TICK_DIV clock cycles (default 163). The first strobe comes TICK_DIV cycles after reset is released.
- R3: On each tick each channel's accumulator becomes (accumulator + duty) mod 256. The channel's port bit for that tick is 1 exactly when that addition carries out of bit 7, and 0 otherwise.
- R4: Over any 256 consecutive ticks with an unchanged duty value d, the channel's bit is high in exactly d ticks. So d=0 gives none, d=1 gives one and d=255 gives 255.
- R5: Channel k drives port bit 2k (channels 0..3 on bits 0, 2, 4, 6). Odd port bits are always 0. All bits change together in the cycle in which the tick strobe is high, and the port holds steady in every other cycle.
- R6: When wr_en is 1 at a clock edge, wr_data (8 bits) is stored as the duty value of the channel selected by wr_addr (0..3). With wr_en at 0, wr_addr and wr_data have no effect. A duty write never changes any accumulator.
- R7: A duty write at the same clock edge that processes a tick does not affect that tick, which still uses the previous duty value. The new value applies from the following tick onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Duty write strobe |
| wr_addr_i | input | ADDR_W (2) | Channel selected by a duty write |
| wr_data_i | input | DUTY_W (8) | Duty value to store |
| tick_o | output | 1 | One-cycle strobe marking a fresh port word |
| port_o | output | 2*NUM_CH (8) | Interleaved channel outputs, channel k on bit 2k |

## Verification
A host duty write and the tick update can land on the same clock edge. In that case the accumulator must add the old duty while the register takes the new one. The bench provokes this by counting forward from an observed tick strobe, so that the write is sampled exactly at the next tick edge. A zero-to-full write is placed there: the old duty forces a low bit for that tick, and any later carry must follow from the unchanged accumulator. Every tick is also compared against a bench model of each accumulator. The model applies each write after the tick it coincides with, so ramps, random writes and the aligned writes all test this ordering.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

   // Largest channel count the interleaved port supports.
   localparam int unsigned PDM_MAX_CH = 4;

   // Distance between neighbouring channel bits on the port word.
   localparam int unsigned PDM_STRIDE = 2;

   // Port bit driven by channel ch.
   function automatic int unsigned lane_bit(input int unsigned ch);
      return ch * PDM_STRIDE;
   endfunction

endpackage

// File: rtl/pdm_tick_div.sv
module pdm_tick_div #(
   parameter int unsigned DIV = 163
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);
   localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("pdm_tick_div: DIV must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   assign tick_o = (cnt_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R2: the count never leaves its window
   a_r2_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST);

   // R2: a tick restarts the period
   a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);

endmodule

// File: rtl/pdm_channel.sv
module pdm_channel #(
   parameter int unsigned DW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          tick_i,
   input  logic          wr_hit_i,
   input  logic [DW-1:0] wr_data_i,
   output logic          carry_o
);
   if (DW < 1) begin : g_bad_dw
      $error("pdm_channel: DW must be at least 1");
   end

   logic [DW-1:0] duty_q;
   logic [DW-1:0] acc_q;
   logic [DW:0]   sum_w;

   assign sum_w   = {1'b0, acc_q} + {1'b0, duty_q};
   assign carry_o = sum_w[DW];

   // Duty register: a write at a tick edge is seen from the next tick on.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         duty_q <= '0;
      end else if (wr_hit_i) begin
         duty_q <= wr_data_i;
      end
   end

   // Phase accumulator advances only on ticks.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q <= '0;
      end else if (tick_i) begin
         acc_q <= sum_w[DW-1:0];
      end
   end

   // R3: phase frozen between ticks, writes included (R6)
   a_r3_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(acc_q));

   // R4: zero duty never carries
   a_r4_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (duty_q == '0) |-> !carry_o);

   // R6: a selected write lands in the duty register
   a_r6_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_hit_i |=> (duty_q == $past(wr_data_i)));

   // R6: no write, no change of duty
   a_r6_duty_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_hit_i |=> $stable(duty_q));

endmodule

// File: rtl/pdm_port_pack.sv
module pdm_port_pack #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned PORT_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic [NUM_CH-1:0] carry_i,
   output logic [PORT_W-1:0] port_o,
   output logic              strobe_o
);
   if (PORT_W < pdm_pkg::PDM_STRIDE * NUM_CH) begin : g_bad_w
      $error("pdm_port_pack: PORT_W too small for NUM_CH lanes");
   end

   function automatic logic [PORT_W-1:0] odd_mask();
      logic [PORT_W-1:0] m;
      m = '0;
      for (int i = 0; i < int'(PORT_W); i++) begin
         if ((i % 2) == 1) m[i] = 1'b1;
      end
      return m;
   endfunction

   localparam logic [PORT_W-1:0] ODD_MASK = odd_mask();

   logic [PORT_W-1:0] port_next;
   logic [PORT_W-1:0] port_q;
   logic              strobe_q;

   // Rebuilt from a cleared word every tick.
   always_comb begin
      port_next = '0;
      for (int c = 0; c < int'(NUM_CH); c++) begin
         port_next[pdm_pkg::lane_bit(c)] = carry_i[c];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         port_q   <= '0;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= tick_i;
         if (tick_i) begin
            port_q <= port_next;
         end
      end
   end

   assign port_o   = port_q;
   assign strobe_o = strobe_q;

   // R5: odd lanes stay low
   a_r5_odd_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (port_q & ODD_MASK) == '0);

   // R5: port only moves on a tick
   a_r5_port_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(port_q));

   // R2: strobe lasts a single cycle
   a_r2_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_q |=> !strobe_q);

endmodule

// File: rtl/pdm_dac_bank.sv
module pdm_dac_bank #(
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned DUTY_W   = 8,
   parameter int unsigned TICK_DIV = 163,
   parameter int unsigned ADDR_W   = 2,
   localparam int unsigned PORT_W  = pdm_pkg::PDM_STRIDE * NUM_CH
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DUTY_W-1:0] wr_data_i,
   output logic              tick_o,
   output logic [PORT_W-1:0] port_o
);
   if (NUM_CH < 1 || NUM_CH > pdm_pkg::PDM_MAX_CH) begin : g_bad_ch
      $error("pdm_dac_bank: NUM_CH must be 1..4");
   end
   if ((2 ** ADDR_W) < NUM_CH) begin : g_bad_addr
      $error("pdm_dac_bank: ADDR_W cannot select every channel");
   end

   logic              tick_w;
   logic [NUM_CH-1:0] carry_w;
   logic [NUM_CH-1:0] hit_w;

   pdm_tick_div #(.DIV(TICK_DIV)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_o (tick_w)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign hit_w[c] = wr_en_i && (wr_addr_i == ADDR_W'(c));

      pdm_channel #(.DW(DUTY_W)) u_ch (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .tick_i    (tick_w),
         .wr_hit_i  (hit_w[c]),
         .wr_data_i (wr_data_i),
         .carry_o   (carry_w[c])
      );
   end

   pdm_port_pack #(.NUM_CH(NUM_CH), .PORT_W(PORT_W)) u_pack (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_w),
      .carry_i  (carry_w),
      .port_o   (port_o),
      .strobe_o (tick_o)
   );

   // R6: at most one channel takes a write
   a_r6_one_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(hit_w));

   // R2: the strobe follows the internal tick by one register
   a_r2_strobe_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_w |=> tick_o);

endmodule

// File: tb/pdm_dac_bank_bench.sv
`timescale 1ns/1ps
module pdm_dac_bank_bench;
   localparam int NCH = 4;
   localparam int DIV = 13;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       tick_o;
   logic [7:0] port_o;

   always #4 clk = ~clk;

   pdm_dac_bank #(.NUM_CH(NCH), .DUTY_W(8), .TICK_DIV(DIV), .ADDR_W(2)) u_pdm_dac_bank (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .tick_o    (tick_o),
      .port_o    (port_o)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int last_tick = -1;
   int n_ticks = 0;
   bit done = 1'b0;
   bit ticked = 1'b0;
   bit counting = 1'b0;
   int unsigned m_acc [NCH];
   int unsigned m_duty [NCH];
   int win_cnt [NCH];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   function automatic logic [7:0] model_tick();
      logic [7:0] e;
      e = '0;
      for (int c = 0; c < NCH; c++) begin
         int unsigned s;
         s = m_acc[c] + m_duty[c];
         if (s > 255) e[2*c] = 1'b1;
         m_acc[c] = s & 255;
      end
      return e;
   endfunction

   // One clock cycle; samples at the falling edge.
   task automatic step();
      logic [7:0] e;
      @(negedge clk);
      cyc++;
      ticked = tick_o;
      if (tick_o) begin
         n_ticks++;
         e = model_tick();
         // R3 carry bits, R5 layout and odd bits, R6 accumulator continuity
         check(port_o == e, "R3/R5/R6 port word", int'(port_o), int'(e));
         if (last_tick < 0) check(cyc == DIV, "R2 first tick", cyc, DIV);
         else check(cyc - last_tick == DIV, "R2 tick period", cyc - last_tick, DIV);
         last_tick = cyc;
         if (counting) begin
            for (int c = 0; c < NCH; c++) win_cnt[c] += int'(port_o[2*c]);
         end
      end
   endtask

   task automatic do_write(input int c, input int v);
      wr_en = 1'b1;
      wr_addr = 2'(c);
      wr_data = 8'(v);
      step();
      m_duty[c] = v & 255;
      wr_en = 1'b0;
      wr_addr = 2'($urandom);
      wr_data = 8'($urandom);
   endtask

   task automatic run_ticks(input int n);
      int target;
      target = n_ticks + n;
      while (n_ticks < target) step();
   endtask

   task automatic window(input string req);
      for (int c = 0; c < NCH; c++) win_cnt[c] = 0;
      counting = 1'b1;
      run_ticks(256);
      counting = 1'b0;
      for (int c = 0; c < NCH; c++) check(win_cnt[c] == int'(m_duty[c]), req, win_cnt[c], int'(m_duty[c]));
   endtask

   // Write sampled on the same edge as the next tick (R7).
   task automatic aligned_write(input int c, input int v);
      int old;
      old = int'(m_duty[c]);
      do step(); while (!ticked);
      repeat (DIV - 1) step();
      do_write(c, v);
      check(ticked, "R7 write on tick edge", int'(ticked), 1);
      if (old == 0) check(port_o[2*c] == 1'b0, "R7 old duty used", int'(port_o[2*c]), 0);
   endtask

   initial begin
      void'($urandom(32'h5EED_0707));
      for (int c = 0; c < NCH; c++) begin m_acc[c] = 0; m_duty[c] = 0; end
      // R1 reset state
      repeat (4) @(negedge clk);
      check(port_o == 8'h00, "R1 port in reset", int'(port_o), 0);
      check(tick_o == 1'b0, "R1 strobe in reset", int'(tick_o), 0);
      rst_n = 1'b1;
      cyc = 0;
      repeat (3) step();
      check(port_o == 8'h00 && tick_o == 1'b0, "R1 after release", int'(port_o), 0);
      // R1 and R4: no writes means all duties zero
      window("R1 zero window");
      // R4 directed corners
      do_write(0, 1);
      do_write(1, 255);
      do_write(2, 0);
      do_write(3, 128);
      run_ticks(3);
      window("R4 directed window");
      // R6 disabled writes carry garbage and must be ignored
      for (int i = 0; i < 40; i++) begin
         wr_addr = 2'($urandom);
         wr_data = 8'($urandom);
         step();
      end
      window("R6 ignored window");
      // random duties, random write timing
      for (int r = 0; r < 6; r++) begin
         for (int c = 0; c < NCH; c++) begin
            repeat ($urandom_range(0, 20)) step();
            do_write(int'($urandom_range(0, 3)), int'($urandom_range(0, 255)));
         end
         if (r == 2) begin do_write(0, 0); do_write(3, 255); end
         window("R4 random window");
      end
      // R6 ramp and sawtooth, stepped every tick
      for (int i = 0; i < 300; i++) begin
         do step(); while (!ticked);
         do_write(0, int'((m_duty[0] + 1) & 255));
         do_write(1, int'((m_duty[1] + 255) & 255));
      end
      // R7 coincident writes
      do_write(2, 0);
      run_ticks(2);
      aligned_write(2, 255);
      run_ticks(3);
      do_write(3, 0);
      run_ticks(1);
      aligned_write(3, 200);
      aligned_write(0, 7);
      aligned_write(1, 0);
      run_ticks(4);
      window("R4 final window");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d ticks expected completion", n_ticks);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule